// File: doc/BRIEF.md
# Deep Power-Down Exit Sequencer

This block sits on the controller side of a low-power SDRAM. When the chip leaves deep power-down, the memory has lost its configuration and must be brought up again from scratch. A single-cycle wake request starts the recovery: the block drives the clock-enable pin high and holds the command pins at NOP for a long settling window. It then closes all banks and runs a burst of auto-refresh commands. Last, it loads the base mode register and then the extended mode register, observing the minimum gap after each command.

All gaps are stated in nanoseconds and converted to clock cycles from a clock-period parameter. The refresh count is a parameter that is never allowed below eight. The two register values come from input ports, and the bank-address pins select which register is loaded. Once the last gap has passed, a ready flag tells the command scheduler it may take over the pins. The flag stays up until the scheduler reports that it has put the memory back into deep power-down.

Top module: `dpd_exit_seq`

## Requirements
- R1: After reset, and for as long as no wake request arrives, cke_o is low, ready_o is low and the command pins {cs_n,ras_n,cas_n,we_n} carry NOP = 0111.
- R2: A wake request sampled while idle raises cke_o from the next clock edge on, and cke_o stays high for the whole sequence.
- R3: For SETTLE cycles after cke_o rises, only NOP (0111) is driven. SETTLE is ceil(T_SETTLE_NS*1000/CLK_PERIOD_PS). In the next cycle a precharge-all is driven: pins 0010, with addr bit 10 high.
- R4: The first auto-refresh (pins 0001) comes RP cycles after the precharge-all. RP is the tRP time converted to cycles and rounded up, with a floor of 2.
- R5: Exactly max(8, N_REFRESH) auto-refresh commands are issued, each RC cycles after the previous one. RC is converted and rounded up in the same way, with a floor of 2.
- R6: RC cycles after the last auto-refresh, a mode register set is driven: pins 0000, addr = mode_i, ba = 00.
- R7: MRD cycles after the mode register set, an extended mode register set is driven: pins 0000, addr = ext_mode_i, ba = 10. MRD is converted and rounded up, with a floor of 2.
- R8: ready_o rises MRD cycles after the extended mode register set. It then stays high, with NOP on the pins, while further wake requests arrive.
- R9: A wake request that arrives while the sequence is running changes neither the command schedule nor the ready timing.
- R10: sleep_i sampled while ready_o is high returns the block to idle on the next edge (cke_o low, ready_o low, NOP). A later wake request then runs the complete sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Request to leave deep power-down |
| sleep_i | input | 1 | Scheduler has re-entered deep power-down |
| mode_i | input | ADDR_W | Value for the base mode register |
| ext_mode_i | input | ADDR_W | Value for the extended mode register |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus |
| ba_o | output | 2 | Bank address |
| ready_o | output | 1 | New commands may be issued |

## Verification
A state register that is stuck or skips a state shows up at the pins within one gap length. A command is then missing, appears twice, or lands off its expected cycle, so the bench compares every cycle from the wake edge to the ready edge against a schedule it computes itself. A gap timer that loads the wrong value shifts every later command by the same offset and is caught at the next command edge. A refresh counter off by one moves the mode register set by one RC period. A wake accepted mid-sequence would restart the settling window and shift everything after it.

// File: rtl/dpd_exit_pkg.sv
package dpd_exit_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETTLE, ST_PRE, ST_WRP, ST_REF, ST_WRC,
    ST_MRS, ST_WMRS, ST_EMRS, ST_WEMRS, ST_READY
  } seq_state_e;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS, CMD_EMRS
  } seq_cmd_e;
endpackage

// File: rtl/dpd_gap_timer.sv
module dpd_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dpd_ref_counter.sv
module dpd_ref_counter #(
  parameter int REF_N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int W = $clog2(REF_N + 1);
  localparam logic [W-1:0] LAST = W'(REF_N);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  // R5: burst never runs past its length
  assert_ref_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |-> !inc_i);
endmodule

// File: rtl/dpd_pin_drv.sv
module dpd_pin_drv
  import dpd_exit_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  seq_cmd_e          cmd_i,
  input  logic [ADDR_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] ext_mode_i,
  output logic [3:0]        pins_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        ba_o
);
  always_comb begin
    pins_o = 4'b0111;
    addr_o = '0;
    ba_o   = 2'b00;
    unique case (cmd_i)
      CMD_PRE: begin
        pins_o     = 4'b0010;
        addr_o[10] = 1'b1;
      end
      CMD_REF:  pins_o = 4'b0001;
      CMD_MRS: begin
        pins_o = 4'b0000;
        addr_o = mode_i;
      end
      CMD_EMRS: begin
        pins_o = 4'b0000;
        addr_o = ext_mode_i;
        ba_o   = 2'b10;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dpd_exit_seq.sv
module dpd_exit_seq
  import dpd_exit_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_SETTLE_NS   = 200000,
  parameter int T_RP_NS       = 20,
  parameter int T_RC_NS       = 70,
  parameter int T_MRD_NS      = 20,
  parameter int N_REFRESH     = 8,
  parameter int ADDR_W        = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_i,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] ext_mode_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        ba_o,
  output logic              ready_o
);
  localparam int SET_RAW = (T_SETTLE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RP_RAW  = (T_RP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RC_RAW  = (T_RC_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int MRD_RAW = (T_MRD_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SET_CYC = (SET_RAW < 1) ? 1 : SET_RAW;
  localparam int RP_CYC  = (RP_RAW < 2) ? 2 : RP_RAW;
  localparam int RC_CYC  = (RC_RAW < 2) ? 2 : RC_RAW;
  localparam int MRD_CYC = (MRD_RAW < 2) ? 2 : MRD_RAW;
  localparam int REF_N   = (N_REFRESH < 8) ? 8 : N_REFRESH;
  localparam int MAX_CYC = (SET_CYC > RC_CYC) ? SET_CYC : RC_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] LD_SET = CNT_W'(SET_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(RP_CYC - 2);
  localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(RC_CYC - 2);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(MRD_CYC - 2);

  seq_state_e       state_q, state_d;
  seq_cmd_e         cmd;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             gap_done, ref_clr, ref_inc, ref_done;
  logic [3:0]       pins;

  dpd_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(ld), .val_i(ld_val), .zero_o(gap_done)
  );

  dpd_ref_counter #(.REF_N(REF_N)) u_refcnt (
    .clk_i, .rst_ni, .clr_i(ref_clr), .inc_i(ref_inc), .done_o(ref_done)
  );

  dpd_pin_drv #(.ADDR_W(ADDR_W)) u_drv (
    .cmd_i(cmd), .mode_i, .ext_mode_i, .pins_o(pins), .addr_o, .ba_o
  );

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    ref_clr = 1'b0;
    ref_inc = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (wake_i) begin state_d = ST_SETTLE; ld = 1'b1; ld_val = LD_SET; end
      ST_SETTLE: if (gap_done) state_d = ST_PRE;
      ST_PRE:    begin ref_clr = 1'b1; ld = 1'b1; ld_val = LD_RP; state_d = ST_WRP; end
      ST_WRP:    if (gap_done) state_d = ST_REF;
      ST_REF:    begin ref_inc = 1'b1; ld = 1'b1; ld_val = LD_RC; state_d = ST_WRC; end
      ST_WRC:    if (gap_done) state_d = ref_done ? ST_MRS : ST_REF;
      ST_MRS:    begin ld = 1'b1; ld_val = LD_MRD; state_d = ST_WMRS; end
      ST_WMRS:   if (gap_done) state_d = ST_EMRS;
      ST_EMRS:   begin ld = 1'b1; ld_val = LD_MRD; state_d = ST_WEMRS; end
      ST_WEMRS:  if (gap_done) state_d = ST_READY;
      ST_READY:  if (sleep_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:  cmd = CMD_PRE;
      ST_REF:  cmd = CMD_REF;
      ST_MRS:  cmd = CMD_MRS;
      ST_EMRS: cmd = CMD_EMRS;
      default: cmd = CMD_NOP;
    endcase
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins;
  assign cke_o   = (state_q != ST_IDLE);
  assign ready_o = (state_q == ST_READY);

  // R1: clock enable stays low without a wake request
  assert_cke_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && !wake_i) |=> !cke_o);
  // R3: every precharge closes all banks
  assert_pre_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0010) |-> addr_o[10]);
  // R8: nothing but NOP once ready
  assert_ready_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cke_o && pins == 4'b0111));
  // R9: a running sequence is never dropped
  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && !ready_o) |=> cke_o);
  // R7: ready never coincides with the extended load
  assert_emrs_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0000 && ba_o == 2'b10) |=> !ready_o);
endmodule

// File: tb/dpd_exit_seq_bench.sv
module dpd_exit_seq_bench;
  localparam int CLK_NS  = 10;
  localparam int PER_PS  = CLK_NS * 1000;
  localparam int SET_NS  = 1000;
  localparam int RP_NS   = 25;
  localparam int RC_NS   = 65;
  localparam int MRD_NS  = 15;
  localparam int NREF_P  = 5;
  localparam int AW      = 12;

  // expected cycle counts derived from the requirements
  localparam int SET  = (SET_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int RP   = ((RP_NS * 1000 + PER_PS - 1) / PER_PS < 2) ? 2 : (RP_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int RC   = ((RC_NS * 1000 + PER_PS - 1) / PER_PS < 2) ? 2 : (RC_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int MRD  = ((MRD_NS * 1000 + PER_PS - 1) / PER_PS < 2) ? 2 : (MRD_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int NREF = (NREF_P < 8) ? 8 : NREF_P;
  localparam int I_MRS  = SET + RP + NREF * RC;
  localparam int I_EMRS = I_MRS + MRD;
  localparam int I_RDY  = I_EMRS + MRD;

  logic clk = 1'b0, rst_n = 1'b0, wake = 1'b0, sleep = 1'b0;
  logic [AW-1:0] mode = '0, ext = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [AW-1:0] addr;
  logic [1:0] ba;
  wire  [3:0] pins = {cs_n, ras_n, cas_n, we_n};
  int tot = 0, bad = 0;

  always #(CLK_NS / 2) clk = ~clk;

  dpd_exit_seq #(
    .CLK_PERIOD_PS(PER_PS), .T_SETTLE_NS(SET_NS), .T_RP_NS(RP_NS),
    .T_RC_NS(RC_NS), .T_MRD_NS(MRD_NS), .N_REFRESH(NREF_P), .ADDR_W(AW)
  ) u_dpd_exit_seq (
    .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .sleep_i(sleep),
    .mode_i(mode), .ext_mode_i(ext), .cke_o(cke), .cs_n_o(cs_n),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr),
    .ba_o(ba), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!cke && !ready && pins == 4'b0111, "R1 in reset", {cke, ready, pins}, 6'b000111);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!cke && !ready && pins == 4'b0111, "R1 idle no wake", {cke, ready, pins}, 6'b000111);
  endtask

  // full sequence from wake to ready; poke adds stray wake pulses mid-run
  task automatic t_sequence(input logic [AW-1:0] mr, input logic [AW-1:0] emr, input bit poke);
    int cke_err = 0, nop_err = 0, rdy_err = 0;
    logic [3:0] exp;
    mode = mr;
    ext  = emr;
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
    for (int i = 0; i <= I_RDY + 3; i++) begin
      if (i > 0) @(negedge clk);
      exp = 4'b0111;
      if (i == SET) exp = 4'b0010;
      else if (i >= SET + RP && i < I_MRS && (i - SET - RP) % RC == 0) exp = 4'b0001;
      else if (i == I_MRS || i == I_EMRS) exp = 4'b0000;
      if (!cke) cke_err++;
      if ((ready == 1'b1) != (i >= I_RDY)) rdy_err++;
      if (exp == 4'b0111) begin
        if (pins != exp) nop_err++;
      end else if (i == SET) begin
        chk(pins == exp && addr[10], "R3 precharge-all", {pins, addr[10]}, {exp, 1'b1});
      end else if (i == SET + RP) begin
        chk(pins == exp, "R4 first refresh", pins, exp);
      end else if (exp == 4'b0001) begin
        chk(pins == exp, "R5 refresh spacing", pins, exp);
      end else if (i == I_MRS) begin
        chk(pins == exp && addr == mr && ba == 2'b00, "R6 mode load", {pins, ba, addr}, {exp, 2'b00, mr});
      end else begin
        chk(pins == exp && addr == emr && ba == 2'b10, "R7 ext mode load", {pins, ba, addr}, {exp, 2'b10, emr});
      end
      if (i == I_RDY) chk(ready, "R8 ready edge", ready, 1);
      if (poke && (i == 40 || i == SET + RP + 1 || i == I_MRS)) wake = 1'b1;
      else wake = 1'b0;
    end
    wake = 1'b0;
    chk(cke_err == 0, "R2 cke held", cke_err, 0);
    chk(nop_err == 0, "R3 only NOP between commands", nop_err, 0);
    chk(rdy_err == 0, poke ? "R9 ready timing with stray wake" : "R8 ready timing", rdy_err, 0);
  endtask

  task automatic t_ready_hold;
    int err = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wake = (i % 3 == 0);
      if (!ready || pins != 4'b0111 || !cke) err++;
    end
    @(negedge clk) wake = 1'b0;
    chk(err == 0 && ready, "R8 ready holds under wake", err, 0);
  endtask

  task automatic t_sleep;
    @(negedge clk) sleep = 1'b1;
    @(negedge clk) sleep = 1'b0;
    chk(!cke && !ready && pins == 4'b0111, "R10 back to idle", {cke, ready, pins}, 6'b000111);
    repeat (3) @(negedge clk);
    chk(!cke, "R10 idle holds", cke, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tot++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 20000, 0);
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence(12'h033, 12'h020, 1'b0);
    t_ready_hold();
    t_sleep();
    t_sequence(12'h5a7, 12'hc41, 1'b1);   // R9 and R10 restart
    t_sleep();
    t_sequence(12'hfff, 12'h000, 1'b0);
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule